// File: doc/BRIEF.md
# Cascaded programmable high/low clock divider

This block is one output channel of a clock distribution tree. It divides its input clock in two cascaded stages. Each stage spends a programmable number of input ticks low and a programmable number high, so the duty cycle need not be 50 %. The second stage counts the rising edges of the first stage's output, so the channel period is the product of the two stage periods.

Each stage has its own count fields, a start level and a bypass bit. A bypassed stage passes its input straight through. When both stages are bypassed, the input clock itself appears at the output.

A chip-wide synchronisation input puts both stages back to a known phase. The channel can be told to ignore it. Only a channel that ignores synchronisation may have its output pinned high. A duty-cycle-correction disable bit is only registered and brought out for the analog driver.

The count fields and start levels are taken into a shadow copy at two moments: during a hold (reset or obeyed sync), and, for the counts only, when a full output period of that stage ends. Changing them mid-period therefore never produces a runt pulse. The bypass bits act at once.

Top module: `cdiv_channel`

## Requirements
- R1: A counting stage with low field L and high field H (each CNT_W bits, value = ticks minus one) holds its level low for L+1 ticks and high for H+1 ticks, giving a period of L+H+2 ticks. Stage 1 ticks on every rising edge of `clk`.
- R2: After a hold ends, a counting stage starts at its start-level bit (0 = low phase first, 1 = high phase first) and then alternates phases.
- R3: Stage 2 ticks once per rising edge of stage 1's output, so with both stages counting, the channel output is stage 1's output divided again by stage 2.
- R4: A stage whose bypass bit is 1 does not count and passes its input events straight on. With only stage 1 bypassed, stage 2 ticks on every `clk` edge. With only stage 2 bypassed, `clk_out` equals stage 1's level.
- R5: With both bypass bits set and no force, `clk_out` follows `clk` (high in the high half of the clock, low in the low half).
- R6: While `sync_i`=1 and `nosync_i`=0, both stages hold at count zero with their levels at their start-level bits, and `hold_o` is 1 one cycle later. Counting resumes at the first `clk` rising edge with `sync_i`=0. `hold_o` then stays 1 until the edge at which the channel output rises.
- R7: With `nosync_i`=1, `sync_i` has no effect on counting or on `hold_o`.
- R8: `force_hi_i`=1 drives `clk_out` high only while `nosync_i`=1. With `nosync_i`=0 it has no effect, and counting runs on underneath in both cases.
- R9: New count fields take effect only at the end of the current full period of that stage (when it returns to its start level) or during a hold.
- R10: Synchronous active-high `rst` acts as an obeyed sync and also clears the registered duty-correction flag. After reset with all-zero configuration, `clk_out`=0 and `hold_o`=1.
- R11: `dcc_off_o` equals `dcc_off_i` registered by one `clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Chip-wide synchronisation request |
| s1_low | input | CNT_W | Stage 1 low ticks minus one |
| s1_high | input | CNT_W | Stage 1 high ticks minus one |
| s1_start | input | 1 | Stage 1 start level |
| s1_bypass | input | 1 | Stage 1 bypass |
| s2_low | input | CNT_W | Stage 2 low ticks minus one |
| s2_high | input | CNT_W | Stage 2 high ticks minus one |
| s2_start | input | 1 | Stage 2 start level |
| s2_bypass | input | 1 | Stage 2 bypass |
| nosync_i | input | 1 | 1: ignore `sync_i` |
| force_hi_i | input | 1 | Pin output high (only with `nosync_i`=1) |
| dcc_off_i | input | 1 | Duty-cycle correction disable |
| clk_out | output | 1 | Divided channel clock |
| hold_o | output | 1 | Held or not yet risen since last hold |
| dcc_off_o | output | 1 | Registered duty-correction disable |

## Verification
The channel is driven in these configurations:
- stage 1 alone with an uneven 3/5 split and both start levels, which tells a swapped low and high field from a wrong start phase;
- both stages counting with short, unequal fields, which shows whether stage 2 advances on stage-1 rising edges rather than on every tick;
- each bypass combination, which separates the routing choices;
- a mid-period change of the count fields, which shows whether the change waits for the period boundary;
- sync pulses with nosync clear and set, each combined with force-high, which separates obeying from ignoring and an effective force from a dead one.

A behavioural period-position model in the bench predicts `clk_out` and `hold_o` for every cycle.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    // Source that drives the channel output
    typedef enum logic [1:0] {
        SRC_FORCE = 2'd0,
        SRC_CLK   = 2'd1,
        SRC_STAGE = 2'd2
    } cdiv_src_e;

endpackage

// File: rtl/cdiv_stage.sv
module cdiv_stage #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             hold,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] low_cfg,
    input  logic [CNT_W-1:0] high_cfg,
    input  logic             start_cfg,
    input  logic             bypass_cfg,
    output logic             lvl_o,
    output logic             rise_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
        logic [CNT_W-1:0] sh_low;
        logic [CNT_W-1:0] sh_high;
        logic             sh_start;
    } stage_st_t;

    stage_st_t st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             at_end;
    logic             rise_d;

    always_comb begin
        st_d   = st_q;
        rise_d = 1'b0;
        limit  = st_q.lvl ? st_q.sh_high : st_q.sh_low;
        at_end = (st_q.cnt == limit);
        if (hold) begin
            st_d.cnt      = '0;
            st_d.lvl      = start_cfg;
            st_d.sh_low   = low_cfg;
            st_d.sh_high  = high_cfg;
            st_d.sh_start = start_cfg;
        end else if (bypass_cfg) begin
            // counting idle; input events pass straight on
            st_d.cnt     = '0;
            st_d.lvl     = st_q.sh_start;
            st_d.sh_low  = low_cfg;
            st_d.sh_high = high_cfg;
            rise_d       = tick_en;
        end else if (tick_en) begin
            if (at_end) begin
                st_d.cnt = '0;
                st_d.lvl = ~st_q.lvl;
                rise_d   = ~st_q.lvl;
                // returning to the start level closes a full period
                if (~st_q.lvl == st_q.sh_start) begin
                    st_d.sh_low  = low_cfg;
                    st_d.sh_high = high_cfg;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lvl_o  = st_q.lvl;
    assign rise_o = rise_d;

endmodule

// File: rtl/cdiv_outmux.sv
module cdiv_outmux #(
    parameter int N_STAGES = 2
) (
    input  logic                clk,
    input  logic                force_eff,
    input  logic [N_STAGES-1:0] stage_lvl,
    input  logic [N_STAGES-1:0] stage_byp,
    output logic                out_o
);
    import cdiv_pkg::*;

    cdiv_src_e sel;
    logic      stage_val;

    always_comb begin
        sel       = SRC_CLK;
        stage_val = 1'b0;
        // the last counting stage in the chain owns the output
        for (int i = 0; i < N_STAGES; i++) begin
            if (!stage_byp[i]) begin
                sel       = SRC_STAGE;
                stage_val = stage_lvl[i];
            end
        end
        if (force_eff) sel = SRC_FORCE;
        case (sel)
            SRC_FORCE: out_o = 1'b1;
            SRC_STAGE: out_o = stage_val;
            default:   out_o = clk;
        endcase
    end

endmodule

// File: rtl/cdiv_channel.sv
module cdiv_channel #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] s1_low,
    input  logic [CNT_W-1:0] s1_high,
    input  logic             s1_start,
    input  logic             s1_bypass,
    input  logic [CNT_W-1:0] s2_low,
    input  logic [CNT_W-1:0] s2_high,
    input  logic             s2_start,
    input  logic             s2_bypass,
    input  logic             nosync_i,
    input  logic             force_hi_i,
    input  logic             dcc_off_i,
    output logic             clk_out,
    output logic             hold_o,
    output logic             dcc_off_o
);
    localparam int N_STAGES = 2;

    typedef struct packed {
        logic busy;
        logic dcc;
    } chan_st_t;

    chan_st_t ch_d, ch_q;

    logic             hold;
    logic             force_eff;
    logic [N_STAGES:0] tick;
    logic [N_STAGES-1:0] lvl;
    logic [N_STAGES-1:0] byp;
    logic [N_STAGES-1:0] start_a;
    logic [CNT_W-1:0] low_a  [N_STAGES];
    logic [CNT_W-1:0] high_a [N_STAGES];

    assign hold      = rst | (sync_i & ~nosync_i);
    assign force_eff = force_hi_i & nosync_i;

    assign low_a[0]  = s1_low;
    assign low_a[1]  = s2_low;
    assign high_a[0] = s1_high;
    assign high_a[1] = s2_high;
    assign start_a   = {s2_start, s1_start};
    assign byp       = {s2_bypass, s1_bypass};
    assign tick[0]   = 1'b1;

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        cdiv_stage #(.CNT_W(CNT_W)) u_stage (
            .clk        (clk),
            .hold       (hold),
            .tick_en    (tick[g]),
            .low_cfg    (low_a[g]),
            .high_cfg   (high_a[g]),
            .start_cfg  (start_a[g]),
            .bypass_cfg (byp[g]),
            .lvl_o      (lvl[g]),
            .rise_o     (tick[g+1])
        );
    end

    cdiv_outmux #(.N_STAGES(N_STAGES)) u_mux (
        .clk       (clk),
        .force_eff (force_eff),
        .stage_lvl (lvl),
        .stage_byp (byp),
        .out_o     (clk_out)
    );

    // tick[N_STAGES] marks the edge at which the channel output rises
    always_comb begin
        ch_d = ch_q;
        if (hold) begin
            ch_d.busy = 1'b1;
        end else if (tick[N_STAGES]) begin
            ch_d.busy = 1'b0;
        end
        ch_d.dcc = rst ? 1'b0 : dcc_off_i;
    end

    always_ff @(posedge clk) begin
        ch_q <= ch_d;
    end

    assign hold_o    = ch_q.busy;
    assign dcc_off_o = ch_q.dcc;

endmodule

// File: rtl/cdiv_channel_chk.sv
module cdiv_channel_chk (
    input logic clk,
    input logic rst,
    input logic sync_i,
    input logic nosync_i,
    input logic force_hi_i,
    input logic s1_bypass,
    input logic s2_bypass,
    input logic s2_start,
    input logic dcc_off_i,
    input logic clk_out,
    input logic hold_o,
    input logic dcc_off_o
);

    // R10: reset leaves the channel held
    a_r10_reset_holds: assert property (@(posedge clk) rst |=> hold_o);

    // R6: an obeyed sync marks the channel as held
    a_r6_sync_holds: assert property (@(posedge clk) disable iff (rst)
        (sync_i && !nosync_i) |=> hold_o);

    // R6: an obeyed sync parks a counting stage 2 at its start level
    a_r6_sync_start_level: assert property (@(posedge clk) disable iff (rst)
        (sync_i && !nosync_i && !s2_bypass) |=> (clk_out == $past(s2_start)));

    // R8: an effective force pins the output high
    a_r8_force_high: assert property (@(posedge clk) disable iff (rst)
        (force_hi_i && nosync_i) |-> clk_out);

    // R11: duty-correction flag is delayed by one edge
    a_r11_dcc_delay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (dcc_off_o == $past(dcc_off_i)));

    // R4: a held channel with stage 1 bypassed but stage 2 counting is not clock-following
    a_r4_byp1_counts: assert property (@(posedge clk) disable iff (rst)
        (s1_bypass && !s2_bypass && !force_hi_i && sync_i && !nosync_i)
        |=> (clk_out == $past(s2_start)));

endmodule

bind cdiv_channel cdiv_channel_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sync_i     (sync_i),
    .nosync_i   (nosync_i),
    .force_hi_i (force_hi_i),
    .s1_bypass  (s1_bypass),
    .s2_bypass  (s2_bypass),
    .s2_start   (s2_start),
    .dcc_off_i  (dcc_off_i),
    .clk_out    (clk_out),
    .hold_o     (hold_o),
    .dcc_off_o  (dcc_off_o)
);

// File: tb/cdiv_channel_tb.sv
`timescale 1ns/100ps
module cdiv_channel_tb;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1, sync_i = 1'b0;
    logic [CW-1:0] s1_low = '0, s1_high = '0, s2_low = '0, s2_high = '0;
    logic s1_start = 0, s1_bypass = 0, s2_start = 0, s2_bypass = 0;
    logic nosync_i = 0, force_hi_i = 0, dcc_off_i = 0;
    logic clk_out, hold_o, dcc_off_o;

    always #2.5 clk = ~clk;

    cdiv_channel #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .sync_i(sync_i),
        .s1_low(s1_low), .s1_high(s1_high), .s1_start(s1_start), .s1_bypass(s1_bypass),
        .s2_low(s2_low), .s2_high(s2_high), .s2_start(s2_start), .s2_bypass(s2_bypass),
        .nosync_i(nosync_i), .force_hi_i(force_hi_i), .dcc_off_i(dcc_off_i),
        .clk_out(clk_out), .hold_o(hold_o), .dcc_off_o(dcc_off_o)
    );

    int checks = 0, failures = 0, cyc = 0;
    bit started = 0, done = 0;
    string cur_req = "R10";

    // reference model: position inside the period of each stage
    int pos [2] = '{0, 0};
    int shl [2] = '{0, 0};
    int shh [2] = '{0, 0};
    bit shs [2] = '{0, 0};
    bit busy_m = 1, dcc_m = 0;

    function automatic bit lvl_of(int k);
        if (shs[k]) return (pos[k] < shh[k] + 1);
        return (pos[k] >= shl[k] + 1);
    endfunction

    function automatic int cfg_low(int k);
        return (k == 0) ? int'(s1_low) : int'(s2_low);
    endfunction
    function automatic int cfg_high(int k);
        return (k == 0) ? int'(s1_high) : int'(s2_high);
    endfunction

    always @(posedge clk) begin
        bit h, t, old, byp, st;
        h = rst || (sync_i && !nosync_i);
        t = 1;
        for (int k = 0; k < 2; k++) begin
            byp = (k == 0) ? s1_bypass : s2_bypass;
            st  = (k == 0) ? s1_start : s2_start;
            if (h) begin
                pos[k] = 0; shl[k] = cfg_low(k); shh[k] = cfg_high(k); shs[k] = st;
                t = 0;
            end else if (byp) begin
                pos[k] = 0; shl[k] = cfg_low(k); shh[k] = cfg_high(k);
            end else if (t) begin
                old = lvl_of(k);
                pos[k]++;
                if (pos[k] == shl[k] + shh[k] + 2) begin
                    pos[k] = 0; shl[k] = cfg_low(k); shh[k] = cfg_high(k);
                end
                t = !old && lvl_of(k);
            end
        end
        busy_m = h ? 1'b1 : (busy_m && !t);
        dcc_m  = rst ? 1'b0 : dcc_off_i;
        started = 1;
        cyc++;
        if (cyc > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    function automatic bit exp_out();
        if (force_hi_i && nosync_i) return 1'b1;
        if (!s2_bypass) return lvl_of(1);
        if (!s1_bypass) return lvl_of(0);
        return clk;
    endfunction

    task automatic check(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            check("clk_out", clk_out, exp_out());
            check("hold_o", hold_o, busy_m);
            check("dcc_off_o", dcc_off_o, dcc_m);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic sync_pulse();
        sync_i = 1; cycles(2); sync_i = 0;
    endtask

    initial begin
        // R10: reset state with zero configuration
        cur_req = "R10";
        cycles(3);
        check("reset clk_out", clk_out, 1'b0);
        check("reset hold_o", hold_o, 1'b1);
        rst = 0;

        // R1: stage 1 alone, 3 low / 5 high
        cur_req = "R1";
        s2_bypass = 1; s1_low = 2; s1_high = 4;
        sync_pulse();
        cycles(40);

        // R2 and R6: start high after a sync
        cur_req = "R2";
        s1_start = 1;
        sync_pulse();
        cycles(30);
        cur_req = "R6";
        sync_i = 1; cycles(6);
        check("hold during sync", hold_o, 1'b1);
        sync_i = 0; cycles(20);

        // R3: cascade of two counting stages
        cur_req = "R3";
        s1_start = 0; s2_bypass = 0;
        s1_low = 0; s1_high = 1; s2_low = 1; s2_high = 0; s2_start = 0;
        sync_pulse();
        cycles(60);
        s2_start = 1; s1_low = 2; s2_low = 2; s2_high = 1;
        sync_pulse();
        cycles(80);

        // R4: bypass each stage in turn
        cur_req = "R4";
        s1_bypass = 1; s2_low = 2; s2_high = 3; s2_start = 0;
        sync_pulse();
        cycles(40);
        s1_bypass = 0; s2_bypass = 1;
        cycles(30);

        // R5: both stages bypassed, output follows clk
        cur_req = "R5";
        s1_bypass = 1;
        cycles(6);
        @(posedge clk); #1;
        check("bypass high half", clk_out, 1'b1);
        cycles(4);

        // R9: change counts in mid-period
        cur_req = "R9";
        s1_bypass = 0; s2_bypass = 1; s1_start = 0; s1_low = 3; s1_high = 3;
        sync_pulse();
        cycles(5);
        s1_low = 0; s1_high = 0;
        cycles(30);
        s1_low = 5; s1_high = 1;
        cycles(3);
        s2_bypass = 0; s2_low = 0; s2_high = 2;
        cycles(60);

        // R7: sync ignored with nosync set
        cur_req = "R7";
        nosync_i = 1;
        sync_i = 1; cycles(25);
        sync_i = 0; cycles(10);

        // R8: force only effective with nosync
        cur_req = "R8";
        force_hi_i = 1;
        cycles(15);
        nosync_i = 0;
        cycles(30);
        sync_pulse();
        cycles(20);
        force_hi_i = 0;

        // R11: duty-correction flag delay
        cur_req = "R11";
        dcc_off_i = 1; cycles(3);
        dcc_off_i = 0; cycles(2);
        dcc_off_i = 1; cycles(1);

        // R10: reset in mid-run
        cur_req = "R10";
        rst = 1; cycles(2);
        check("reset hold_o", hold_o, 1'b1);
        rst = 0; cycles(40);

        finish_run();
    end

endmodule